// File: doc/BRIEF.md
# Trap Entry Control Unit

This unit performs the state update that happens when a hart takes a trap or returns from one. On a trap strobe it decides whether the trap is handled in machine or supervisor mode, then writes that mode's cause, exception PC and trap-value registers, updates the status bits and the privilege level, and computes the handler address from that mode's vector register. It also produces a one-cycle pulse that tells the memory side to drop any outstanding load reservation.

The surrounding core owns the software-visible copies of the status fields, the current privilege, the two vector registers and the two delegation masks. It presents them as plain inputs and picks up the updated values from the registered outputs. A return strobe moves the saved enable bit back into the global enable, restores the saved privilege and redirects the next PC to the stored exception PC of the mode being left. Every input is sampled at the clock edge where a strobe is high, and the block never stalls, so it has no back-pressure.

Top module: `trap_entry_unit`

## Requirements
- R1: While reset is active, the privilege output is machine (3), every status output, every cause, exception-PC and trap-value register and the reservation-clear pulse are zero, and the next PC equals the RESET_PC parameter (default 0).
- R2: A trap is routed to supervisor mode (privilege 1) only when `cur_priv` is user (0) or supervisor (1) and bit number (final cause code) of the selected mask is set. The selected mask is `ideleg` for interrupts (`trap_async`=1) and `edeleg` for exceptions. Every other trap goes to machine mode (3). `priv_o` shows the target one cycle after the strobe.
- R3: On a machine-mode entry, `mpie_o` takes `st_mie`, `mie_o` becomes 0 and `mpp_o` takes `cur_priv`. The supervisor status outputs copy their inputs.
- R4: On a supervisor-mode entry, `spie_o` takes `st_sie`, `sie_o` becomes 0 and `spp_o` takes bit 0 of `cur_priv`. The machine status outputs copy their inputs.
- R5: The target mode's cause register holds the final cause code in its low bits, with bit XLEN-1 set for an interrupt and all other bits zero. The other mode's cause, exception-PC and trap-value registers keep their values.
- R6: The target mode's exception-PC register takes `trap_pc`.
- R7: The target mode's trap-value register takes `trap_badaddr` for a synchronous trap with code 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other synchronous code and for all interrupts it takes zero.
- R8: A synchronous trap with code 8 (environment call) is recorded as code 8 from user, 9 from supervisor and 11 from machine privilege. The remapped code is also the one used for delegation. An interrupt with code 8 is not remapped.
- R9: The next PC is the target vector register with bits [1:0] cleared. When those two bits equal 1 and the trap is an interrupt, 4 times the final cause code is added to it. Any other value of those bits gives the base address alone.
- R10: `resv_clr_o` is high for exactly the cycle after each trap strobe and low otherwise.
- R11: A machine return (`ret_req` with `ret_m`=1) sets `mie_o` to `st_mpie`, sets `mpie_o` to 1, sets `priv_o` to `st_mpp` and sets the next PC to the stored machine exception PC. The other status outputs copy their inputs.
- R12: A supervisor return (`ret_req` with `ret_m`=0) sets `sie_o` to `st_spie`, sets `spie_o` to 1, sets `priv_o` to {0, `st_spp`} and sets the next PC to the stored supervisor exception PC. The other status outputs copy their inputs.
- R13: When a trap strobe and a return strobe are high in the same cycle, only the trap takes effect.
- R14: In a cycle with neither strobe high, all registered outputs keep their values whatever the other inputs do, except `resv_clr_o`, which is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap strobe |
| trap_async | input | 1 | Trap is an interrupt |
| trap_cause | input | CAUSE_W | Raw cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_badaddr | input | XLEN | Faulting address |
| ret_req | input | 1 | Return strobe |
| ret_m | input | 1 | Return from machine (1) or supervisor (0) |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| st_mie | input | 1 | Current machine global enable |
| st_sie | input | 1 | Current supervisor global enable |
| st_mpie | input | 1 | Current machine previous enable |
| st_spie | input | 1 | Current supervisor previous enable |
| st_mpp | input | 2 | Current machine previous privilege |
| st_spp | input | 1 | Current supervisor previous privilege |
| mtvec | input | XLEN | Machine vector register |
| stvec | input | XLEN | Supervisor vector register |
| ideleg | input | NCAUSE | Interrupt delegation mask |
| edeleg | input | NCAUSE | Exception delegation mask |
| priv_o | output | 2 | Privilege after the event |
| mie_o | output | 1 | Machine global enable |
| sie_o | output | 1 | Supervisor global enable |
| mpie_o | output | 1 | Machine previous enable |
| spie_o | output | 1 | Supervisor previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| spp_o | output | 1 | Supervisor previous privilege |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |
| scause_o | output | XLEN | Supervisor cause register |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| next_pc_o | output | XLEN | Handler or return address |
| resv_clr_o | output | 1 | Load reservation clear pulse |

## Verification
The bench builds the unit with XLEN=32 and NCAUSE=16, so CAUSE_W is 4 and the whole cause space fits in a loop. It runs every raw code with both trap kinds, from all three legal privileges, with the relevant delegation bit both set and clear. In each case the unused mask holds the opposite value, so picking the wrong mask shows up. The low bits of each vector register rotate through all four values, which covers direct, vectored and reserved dispatch. Both return flavours are swept over every legal saved privilege and enable.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int unsigned CODE_ECALL_U = 8;
  localparam int unsigned CODE_ECALL_S = 9;
  localparam int unsigned CODE_ECALL_M = 11;

  localparam logic [1:0] VEC_MODE_SPREAD = 2'b01;

  typedef struct packed {
    logic       mie;
    logic       sie;
    logic       mpie;
    logic       spie;
    logic [1:0] mpp;
    logic       spp;
  } status_t;

  // synchronous causes that report a faulting address
  function automatic logic carries_addr(input int unsigned code);
    case (code)
      0, 1, 4, 5, 6, 7, 12, 13, 15: carries_addr = 1'b1;
      default:                      carries_addr = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trap_cause_map.sv
module trap_cause_map
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] code_i,
  input  logic [1:0]         priv_i,
  input  logic [XLEN-1:0]    badaddr_i,
  output logic [CAUSE_W-1:0] code_o,
  output logic [XLEN-1:0]    tval_o
);

  always_comb begin
    code_o = code_i;
    if (!async_i && (code_i == CAUSE_W'(CODE_ECALL_U))) begin
      unique case (priv_i)
        PRV_S:   code_o = CAUSE_W'(CODE_ECALL_S);
        PRV_M:   code_o = CAUSE_W'(CODE_ECALL_M);
        default: code_o = CAUSE_W'(CODE_ECALL_U);
      endcase
    end
  end

  always_comb begin
    if (!async_i && carries_addr(int'(code_i)))
      tval_o = badaddr_i;
    else
      tval_o = '0;
  end

endmodule

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
  import trap_pkg::*;
#(
  parameter int unsigned NCAUSE  = 16,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] code_i,
  input  logic [1:0]         priv_i,
  input  logic [NCAUSE-1:0]  ideleg_i,
  input  logic [NCAUSE-1:0]  edeleg_i,
  output logic               to_s_o
);

  logic [NCAUSE-1:0] mask_sel;
  logic              low_priv;

  assign mask_sel = async_i ? ideleg_i : edeleg_i;
  assign low_priv = (priv_i == PRV_U) || (priv_i == PRV_S);
  assign to_s_o   = low_priv && mask_sel[code_i];

endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic [XLEN-1:0]    tvec_i,
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] code_i,
  output logic [XLEN-1:0]    pc_o
);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base   = {tvec_i[XLEN-1:2], 2'b00};
  assign offset = (async_i && (tvec_i[1:0] == VEC_MODE_SPREAD))
                  ? (XLEN'(code_i) << 2) : '0;
  assign pc_o   = base + offset;

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int unsigned    XLEN     = 32,
  parameter int unsigned    NCAUSE   = 16,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  localparam int unsigned   CAUSE_W  = $clog2(NCAUSE)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic               trap_async,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [XLEN-1:0]    trap_badaddr,
  input  logic               ret_req,
  input  logic               ret_m,
  input  logic [1:0]         cur_priv,
  input  logic               st_mie,
  input  logic               st_sie,
  input  logic               st_mpie,
  input  logic               st_spie,
  input  logic [1:0]         st_mpp,
  input  logic               st_spp,
  input  logic [XLEN-1:0]    mtvec,
  input  logic [XLEN-1:0]    stvec,
  input  logic [NCAUSE-1:0]  ideleg,
  input  logic [NCAUSE-1:0]  edeleg,
  output logic [1:0]         priv_o,
  output logic               mie_o,
  output logic               sie_o,
  output logic               mpie_o,
  output logic               spie_o,
  output logic [1:0]         mpp_o,
  output logic               spp_o,
  output logic [XLEN-1:0]    mcause_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [XLEN-1:0]    mtval_o,
  output logic [XLEN-1:0]    scause_o,
  output logic [XLEN-1:0]    sepc_o,
  output logic [XLEN-1:0]    stval_o,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               resv_clr_o
);

  localparam int unsigned NMODE  = 2;   // bank 0 supervisor, bank 1 machine
  localparam int unsigned BANK_S = 0;
  localparam int unsigned BANK_M = 1;

  // ---------------- trap decode ----------------
  logic [CAUSE_W-1:0] code_fix;
  logic [XLEN-1:0]    tval_fix;
  logic               to_s;
  logic [XLEN-1:0]    tvec_sel;
  logic [XLEN-1:0]    vec_pc;
  logic [XLEN-1:0]    cause_word;

  trap_cause_map #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_map (
    .async_i   (trap_async),
    .code_i    (trap_cause),
    .priv_i    (cur_priv),
    .badaddr_i (trap_badaddr),
    .code_o    (code_fix),
    .tval_o    (tval_fix)
  );

  trap_deleg_sel #(.NCAUSE(NCAUSE), .CAUSE_W(CAUSE_W)) u_deleg (
    .async_i  (trap_async),
    .code_i   (code_fix),
    .priv_i   (cur_priv),
    .ideleg_i (ideleg),
    .edeleg_i (edeleg),
    .to_s_o   (to_s)
  );

  assign tvec_sel = to_s ? stvec : mtvec;

  trap_vec_gen #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .tvec_i  (tvec_sel),
    .async_i (trap_async),
    .code_i  (code_fix),
    .pc_o    (vec_pc)
  );

  always_comb begin
    cause_word                = '0;
    cause_word[CAUSE_W-1:0]   = code_fix;
    cause_word[XLEN-1]        = trap_async;
  end

  // ---------------- per-mode trap record banks ----------------
  for (genvar g = 0; g < NMODE; g++) begin : g_bank
    logic            wr_en;
    logic [XLEN-1:0] cause_q;
    logic [XLEN-1:0] epc_q;
    logic [XLEN-1:0] tval_q;

    assign wr_en = trap_req && ((g == BANK_S) ? to_s : !to_s);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cause_q <= '0;
        epc_q   <= '0;
        tval_q  <= '0;
      end else if (wr_en) begin
        cause_q <= cause_word;
        epc_q   <= trap_pc;
        tval_q  <= tval_fix;
      end
    end
  end

  assign scause_o = g_bank[BANK_S].cause_q;
  assign sepc_o   = g_bank[BANK_S].epc_q;
  assign stval_o  = g_bank[BANK_S].tval_q;
  assign mcause_o = g_bank[BANK_M].cause_q;
  assign mepc_o   = g_bank[BANK_M].epc_q;
  assign mtval_o  = g_bank[BANK_M].tval_q;

  // ---------------- status / privilege next state ----------------
  status_t         st_in;
  status_t         st_nxt;
  status_t         st_q;
  logic [1:0]      priv_nxt;
  logic [1:0]      priv_q;
  logic [XLEN-1:0] npc_nxt;
  logic [XLEN-1:0] npc_q;
  logic            upd;

  assign st_in = '{mie: st_mie, sie: st_sie, mpie: st_mpie, spie: st_spie,
                   mpp: st_mpp, spp: st_spp};
  assign upd   = trap_req || ret_req;

  always_comb begin
    st_nxt   = st_in;
    priv_nxt = priv_q;
    npc_nxt  = npc_q;
    if (trap_req) begin
      npc_nxt = vec_pc;
      if (to_s) begin
        st_nxt.spie = st_sie;
        st_nxt.sie  = 1'b0;
        st_nxt.spp  = cur_priv[0];
        priv_nxt    = PRV_S;
      end else begin
        st_nxt.mpie = st_mie;
        st_nxt.mie  = 1'b0;
        st_nxt.mpp  = cur_priv;
        priv_nxt    = PRV_M;
      end
    end else if (ret_req) begin
      if (ret_m) begin
        st_nxt.mie  = st_mpie;
        st_nxt.mpie = 1'b1;
        priv_nxt    = st_mpp;
        npc_nxt     = g_bank[BANK_M].epc_q;
      end else begin
        st_nxt.sie  = st_spie;
        st_nxt.spie = 1'b1;
        priv_nxt    = {1'b0, st_spp};
        npc_nxt     = g_bank[BANK_S].epc_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= '0;
      priv_q     <= PRV_M;
      npc_q      <= RESET_PC;
      resv_clr_o <= 1'b0;
    end else begin
      resv_clr_o <= trap_req;
      if (upd) begin
        st_q   <= st_nxt;
        priv_q <= priv_nxt;
        npc_q  <= npc_nxt;
      end
    end
  end

  assign priv_o    = priv_q;
  assign mie_o     = st_q.mie;
  assign sie_o     = st_q.sie;
  assign mpie_o    = st_q.mpie;
  assign spie_o    = st_q.spie;
  assign mpp_o     = st_q.mpp;
  assign spp_o     = st_q.spp;
  assign next_pc_o = npc_q;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic            trap_async,
  input logic [XLEN-1:0] trap_pc,
  input logic            ret_req,
  input logic            ret_m,
  input logic [1:0]      cur_priv,
  input logic            st_mie,
  input logic            st_mpie,
  input logic [1:0]      priv_o,
  input logic            mie_o,
  input logic            mpie_o,
  input logic [1:0]      mpp_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [XLEN-1:0] mepc_o,
  input logic [XLEN-1:0] sepc_o,
  input logic            resv_clr_o
);

  a_r2_mach_stays_mach: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_priv == 2'd3) |=> (priv_o == 2'd3));

  a_r3_mach_entry_status: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_priv == 2'd3) |=> (!mie_o && mpie_o == $past(st_mie) && mpp_o == 2'd3));

  a_r5_interrupt_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_priv == 2'd3) |=> (mcause_o[XLEN-1] == $past(trap_async)));

  a_r6_epc_captured: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (mepc_o == $past(trap_pc) || sepc_o == $past(trap_pc)));

  a_r10_pulse_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> resv_clr_o);

  a_r10_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> !resv_clr_o);

  a_r11_mret_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && ret_m && !trap_req) |=> (mpie_o && mie_o == $past(st_mpie)));

  a_r14_hold_mach_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && !ret_req) |=> ($stable(mcause_o) && $stable(mepc_o) && $stable(priv_o)));

endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_req   (trap_req),
  .trap_async (trap_async),
  .trap_pc    (trap_pc),
  .ret_req    (ret_req),
  .ret_m      (ret_m),
  .cur_priv   (cur_priv),
  .st_mie     (st_mie),
  .st_mpie    (st_mpie),
  .priv_o     (priv_o),
  .mie_o      (mie_o),
  .mpie_o     (mpie_o),
  .mpp_o      (mpp_o),
  .mcause_o   (mcause_o),
  .mepc_o     (mepc_o),
  .sepc_o     (sepc_o),
  .resv_clr_o (resv_clr_o)
);

// File: tb/trap_entry_unit_tb_top.sv
module trap_entry_unit_tb_top;

  localparam int unsigned XLEN   = 32;
  localparam int unsigned NCAUSE = 16;
  localparam int unsigned CW     = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_req = 1'b0, trap_async = 1'b0;
  logic [CW-1:0]   trap_cause = '0;
  logic [XLEN-1:0] trap_pc = '0, trap_badaddr = '0;
  logic            ret_req = 1'b0, ret_m = 1'b0;
  logic [1:0]      cur_priv = '0;
  logic            st_mie = 0, st_sie = 0, st_mpie = 0, st_spie = 0, st_spp = 0;
  logic [1:0]      st_mpp = '0;
  logic [XLEN-1:0] mtvec = '0, stvec = '0;
  logic [NCAUSE-1:0] ideleg = '0, edeleg = '0;

  logic [1:0]      priv_o, mpp_o;
  logic            mie_o, sie_o, mpie_o, spie_o, spp_o, resv_clr_o;
  logic [XLEN-1:0] mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o, next_pc_o;

  trap_entry_unit #(.XLEN(XLEN), .NCAUSE(NCAUSE)) dut_i (.*);

  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // expected state
  logic [1:0]      e_priv, e_mpp;
  logic            e_mie, e_sie, e_mpie, e_spie, e_spp, e_resv, last_tos;
  logic [XLEN-1:0] e_mcause, e_mepc, e_mtval, e_scause, e_sepc, e_stval, e_npc;
  int unsigned     e_eff;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string pick(input string ctx, input string dflt);
    return (ctx == "trap") ? dflt : ctx;
  endfunction

  task automatic check_all(input string ctx);
    check(pick(ctx, "R2"),  "priv",    priv_o,    e_priv);
    check(pick(ctx, last_tos ? "R4" : "R3"), "mie",  mie_o,  e_mie);
    check(pick(ctx, last_tos ? "R4" : "R3"), "sie",  sie_o,  e_sie);
    check(pick(ctx, last_tos ? "R4" : "R3"), "mpie", mpie_o, e_mpie);
    check(pick(ctx, last_tos ? "R4" : "R3"), "spie", spie_o, e_spie);
    check(pick(ctx, last_tos ? "R4" : "R3"), "mpp",  mpp_o,  e_mpp);
    check(pick(ctx, last_tos ? "R4" : "R3"), "spp",  spp_o,  e_spp);
    check(pick(ctx, "R5"),  "mcause",  mcause_o,  e_mcause);
    check(pick(ctx, "R5"),  "scause",  scause_o,  e_scause);
    check(pick(ctx, "R6"),  "mepc",    mepc_o,    e_mepc);
    check(pick(ctx, "R6"),  "sepc",    sepc_o,    e_sepc);
    check(pick(ctx, "R7"),  "mtval",   mtval_o,   e_mtval);
    check(pick(ctx, "R7"),  "stval",   stval_o,   e_stval);
    check(pick(ctx, "R9"),  "next_pc", next_pc_o, e_npc);
    check(pick(ctx, "R10"), "resv",    resv_clr_o, e_resv);
  endtask

  function automatic bit addr_code(input int unsigned c);
    return (c <= 1) || (c >= 4 && c <= 7) || c == 12 || c == 13 || c == 15;
  endfunction

  function automatic int unsigned final_code(input bit a, input int unsigned c,
                                             input logic [1:0] p);
    if (!a && c == 8) return (p == 2'd1) ? 9 : (p == 2'd3) ? 11 : 8;
    return c;
  endfunction

  task automatic model_trap();
    logic            tos;
    logic [XLEN-1:0] cv, tv, vec;
    int unsigned     eff;
    eff = final_code(trap_async, trap_cause, cur_priv);
    tos = (cur_priv <= 2'd1) && (trap_async ? ideleg[eff] : edeleg[eff]);
    cv  = (trap_async ? 32'h8000_0000 : 32'h0) | eff;
    tv  = (!trap_async && addr_code(eff)) ? trap_badaddr : '0;
    e_mie = st_mie; e_sie = st_sie; e_mpie = st_mpie; e_spie = st_spie;
    e_mpp = st_mpp; e_spp = st_spp;
    if (tos) begin
      e_spie = st_sie; e_sie = 1'b0; e_spp = cur_priv[0]; e_priv = 2'd1;
      e_scause = cv; e_sepc = trap_pc; e_stval = tv; vec = stvec;
    end else begin
      e_mpie = st_mie; e_mie = 1'b0; e_mpp = cur_priv; e_priv = 2'd3;
      e_mcause = cv; e_mepc = trap_pc; e_mtval = tv; vec = mtvec;
    end
    e_npc = {vec[31:2], 2'b00} + ((vec[1:0] == 2'b01 && trap_async) ? eff * 4 : 0);
    e_resv = 1'b1; last_tos = tos; e_eff = eff;
  endtask

  task automatic model_ret();
    e_mie = st_mie; e_sie = st_sie; e_mpie = st_mpie; e_spie = st_spie;
    e_mpp = st_mpp; e_spp = st_spp; e_resv = 1'b0;
    if (ret_m) begin
      e_mie = st_mpie; e_mpie = 1'b1; e_priv = st_mpp; e_npc = e_mepc;
    end else begin
      e_sie = st_spie; e_spie = 1'b1; e_priv = {1'b0, st_spp}; e_npc = e_sepc;
    end
  endtask

  initial begin
    int n;
    // reset values
    e_priv = 2'd3; {e_mie, e_sie, e_mpie, e_spie, e_spp} = '0; e_mpp = '0;
    e_mcause = '0; e_mepc = '0; e_mtval = '0; e_scause = '0; e_sepc = '0;
    e_stval = '0; e_npc = '0; e_resv = 1'b0; last_tos = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;

    n = 0;
    for (int pi = 0; pi < 3; pi++) begin
      for (int a = 0; a < 2; a++) begin
        for (int c = 0; c < 16; c++) begin
          for (int d = 0; d < 2; d++) begin
            logic [1:0]        p;
            int unsigned       eff;
            logic [NCAUSE-1:0] bm;
            p   = (pi == 2) ? 2'd3 : 2'(pi);
            eff = final_code(a[0], c, p);
            bm  = NCAUSE'(1) << eff;
            cur_priv = p; trap_async = a[0]; trap_cause = CW'(c);
            ideleg = (a == 1) == (d == 1) ? bm : ~bm;
            edeleg = ~ideleg;
            trap_pc = 32'h8000_0000 + 32'(n * 4);
            trap_badaddr = 32'hBAD0_0000 | 32'(n);
            {st_mie, st_sie, st_mpie, st_spie, st_spp} = 5'(n);
            st_mpp = 2'(n >> 5);
            mtvec  = 32'h0000_1000 + 32'(n * 64) + 32'(c % 4);
            stvec  = 32'h0004_0000 + 32'(n * 64) + 32'((c + 1) % 4);
            trap_req = 1'b1;
            model_trap();
            @(negedge clk);
            check_all("trap");
            if (!a && c == 8)
              check("R8", "ecall code", last_tos ? scause_o : mcause_o, 64'(eff));
            // idle cycle with disturbed inputs: nothing may move
            trap_req = 1'b0;
            trap_pc = ~trap_pc; trap_badaddr = ~trap_badaddr;
            {st_mie, st_sie, st_mpie, st_spie, st_spp} = ~5'(n);
            cur_priv = ~cur_priv; mtvec = ~mtvec; stvec = ~stvec;
            e_resv = 1'b0;
            @(negedge clk);
            check_all("R14");
            n++;
          end
        end
      end
    end

    // machine returns
    for (int mp = 0; mp < 3; mp++) begin
      for (int pe = 0; pe < 2; pe++) begin
        // fresh machine trap to load a known epc
        cur_priv = 2'd3; trap_async = 1'b0; trap_cause = 4'd2;
        trap_pc = 32'h4000_0000 + 32'(mp * 16 + pe * 4);
        mtvec = 32'h0000_3000; trap_req = 1'b1;
        model_trap();
        @(negedge clk);
        check_all("trap");
        trap_req = 1'b0; ret_req = 1'b1; ret_m = 1'b1;
        st_mpp = (mp == 2) ? 2'd3 : 2'(mp); st_mpie = pe[0];
        st_mie = 1'b0; st_sie = pe[0]; st_spie = ~pe[0]; st_spp = pe[0];
        model_ret();
        @(negedge clk);
        check_all("R11");
        ret_req = 1'b0;
      end
    end

    // supervisor returns
    for (int sp = 0; sp < 2; sp++) begin
      for (int pe = 0; pe < 2; pe++) begin
        cur_priv = 2'(sp); trap_async = 1'b0; trap_cause = 4'd3;
        edeleg = 16'h0008; ideleg = '0;
        trap_pc = 32'h5000_0000 + 32'(sp * 16 + pe * 4);
        stvec = 32'h0000_6001; trap_req = 1'b1;
        model_trap();
        @(negedge clk);
        check_all("trap");
        trap_req = 1'b0; ret_req = 1'b1; ret_m = 1'b0;
        st_spp = sp[0]; st_spie = pe[0]; st_sie = 1'b0;
        st_mie = pe[0]; st_mpie = ~pe[0]; st_mpp = 2'd1;
        model_ret();
        @(negedge clk);
        check_all("R12");
        ret_req = 1'b0;
      end
    end

    // trap and return together: trap wins
    cur_priv = 2'd0; trap_async = 1'b1; trap_cause = 4'd5;
    ideleg = '0; mtvec = 32'h0000_7001; trap_pc = 32'h6000_0010;
    st_mie = 1'b1; st_mpie = 1'b0; st_mpp = 2'd1;
    trap_req = 1'b1; ret_req = 1'b1; ret_m = 1'b1;
    model_trap();
    @(negedge clk);
    check_all("R13");
    trap_req = 1'b0; ret_req = 1'b0;
    e_resv = 1'b0;
    @(negedge clk);
    check_all("R14");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule